// File: doc/BRIEF.md
# PCI Slot Interrupt Router

This block collects the four legacy interrupt pins (INTA, INTB, INTC, INTD) of every PCI device slot and funnels them into a single interrupt request towards the CPU. Each pin passes through a fixed, slot-dependent swizzle that assigns it to one internal interrupt line. Internal line L corresponds to interrupt number 32 + L. Pins of slots outside the routed set have no internal line and are dropped.

A pin produces an event in any cycle where its level differs from the level it had in the previous cycle. Each internal line is configured through two mask inputs. An edge-select bit makes the line emit a single-cycle pulse on the CPU output. When the edge-select bit is clear, the line is level-handled, and its polarity bit decides whether the event drives the output high or low. In a level-handled case the output then holds that value until a later event. If events reach several lines in the same cycle, the line with the lowest index alone decides the output.

The router is meant to sit between the slot interrupt wiring and a CPU-side interrupt controller. Enabling, masking and acknowledging are left to that controller.

Top module: `pci_intx_router`

## Requirements
- R1: While reset is asserted, and after it is released, `cpu_irq` is 0. All pin levels are taken as 0 before the first sampled cycle.
- R2: A pin event is a change of its level from one cycle to the next. Rising and falling changes both count. A pin that holds its level produces no event, and the output stays unchanged.
- R3: Pin p (INTA=0 … INTD=3, input bit `slot*4 + p`) of slot 5 routes to line p.
- R4: All four pins of slot 6 route to line 4. All four pins of slot 7 route to line 5.
- R5: Pin p of slot s, for s in 8 to 12, routes to line (s − 8 + p) + 6.
- R6: Pins of any other slot reach no line. Their events leave `cpu_irq` unchanged.
- R7: If the winning line has its `edge_sel` bit (bit index = line) set, `cpu_irq` is 1 for exactly one cycle and then returns to 0.
- R8: If the winning line is level-handled and its `pol_sel` bit is 1, `cpu_irq` becomes 1. It holds 1 until the next event.
- R9: If the winning line is level-handled and its `pol_sel` bit is 0, `cpu_irq` becomes 0. It holds 0 until the next event.
- R10: When events hit several lines in the same cycle, only the lowest-numbered line among them decides the output.
- R11: `cpu_irq` is registered. It reacts at the first rising clock edge at which the changed pin level is present, and not before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| intx_lvl | input | NUM_SLOTS*4 | Pin levels, bit slot*4+pin, pin 0..3 = INTA..INTD |
| edge_sel | input | NUM_LINES | Per-line edge-select mask, bit index = line |
| pol_sel | input | NUM_LINES | Per-line polarity mask for level-handled lines |
| cpu_irq | output | 1 | Interrupt request to the CPU |

## Verification
The bench uses the default parameters, NUM_SLOTS = 16 and NUM_LINES = 32. With these values the bench can sweep every pin of every slot. The sweep covers both unrouted groups (slots 0–4 and 13–15), all three routed groups, and every line the swizzle can reach. Each pin is driven through the pulse, raise and lower handling, with the expected line worked out arithmetically. Simultaneous events on several lines and stable inputs are covered as separate cases.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

  localparam int PINS_PER_SLOT = 4;
  localparam int IRQ_NUM_BASE  = 32;

  // Fixed slot swizzle; returns -1 when a pin reaches no internal line.
  function automatic int route_line(input int slot, input int pin);
    int ln;
    ln = -1;
    if (slot == 5) begin
      ln = pin % PINS_PER_SLOT;
    end else if (slot == 6) begin
      ln = 4;
    end else if (slot == 7) begin
      ln = 5;
    end else if (slot >= 8 && slot <= 12) begin
      ln = (slot - 8 + pin) + 6;
    end
    return ln;
  endfunction

endpackage

// File: rtl/pirq_change_det.sv
module pirq_change_det #(
  parameter int NUM_IN = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] lvl,
  output logic [NUM_IN-1:0] evt
);

  logic [NUM_IN-1:0] prev_q;
  logic [NUM_IN-1:0] prev_d;
  logic              prev_en;

  always_comb begin
    prev_en = 1'b1;
    prev_d  = lvl;
    evt     = lvl ^ prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
    end else if (prev_en) begin
      prev_q <= prev_d;
    end
  end

  // R2: a level held across two cycles yields no event
  a_r2_stable_no_event: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl == $past(lvl)) |-> (evt == '0));

endmodule

// File: rtl/pirq_slot_map.sv
module pirq_slot_map #(
  parameter int NUM_SLOTS = 16,
  parameter int NUM_LINES = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_SLOTS*pirq_pkg::PINS_PER_SLOT-1:0] pin_evt,
  output logic [NUM_LINES-1:0]          line_evt
);

  localparam int PPS    = pirq_pkg::PINS_PER_SLOT;
  localparam int NUM_IN = NUM_SLOTS * PPS;

  logic [NUM_LINES-1:0] contrib [NUM_IN];

  for (genvar g = 0; g < NUM_IN; g++) begin : g_pin
    localparam int LN = pirq_pkg::route_line(g / PPS, g % PPS);
    if (LN >= 0 && LN < NUM_LINES) begin : g_routed
      assign contrib[g] = {{(NUM_LINES-1){1'b0}}, pin_evt[g]} << LN;
    end else begin : g_dropped
      assign contrib[g] = '0;
    end
  end

  always_comb begin
    line_evt = '0;
    for (int i = 0; i < NUM_IN; i++) begin
      line_evt = line_evt | contrib[i];
    end
  end

  // R6: without any pin event no line can be hit
  a_r6_quiet_lines: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_evt == '0) |-> (line_evt == '0));

endmodule

// File: rtl/pirq_prio_pick.sv
module pirq_prio_pick #(
  parameter int NUM_LINES = 32,
  localparam int LW = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] line_evt,
  output logic                 win_vld,
  output logic [LW-1:0]        win_idx
);

  localparam logic [NUM_LINES-1:0] ONE = 1;

  always_comb begin
    win_vld = 1'b0;
    win_idx = '0;
    for (int l = NUM_LINES - 1; l >= 0; l--) begin
      if (line_evt[l]) begin
        win_vld = 1'b1;
        win_idx = LW'(l);
      end
    end
  end

  // R10: any hit line yields a winner, the winner is hit, nothing below it is
  a_r10_winner_present: assert property (@(posedge clk) disable iff (!rst_n)
    (line_evt != '0) |-> win_vld);
  a_r10_winner_hit: assert property (@(posedge clk) disable iff (!rst_n)
    win_vld |-> line_evt[win_idx]);
  a_r10_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    win_vld |-> ((line_evt & ((ONE << win_idx) - ONE)) == '0));

endmodule

// File: rtl/pirq_out_ctl.sv
module pirq_out_ctl #(
  parameter int NUM_LINES = 32,
  localparam int LW = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 win_vld,
  input  logic [LW-1:0]        win_idx,
  input  logic [NUM_LINES-1:0] edge_sel,
  input  logic [NUM_LINES-1:0] pol_sel,
  output logic                 irq
);

  logic irq_q, irq_d;
  logic pulse_q, pulse_d;
  logic upd_en;
  logic win_edge, win_pol;

  always_comb begin
    win_edge = edge_sel[win_idx];
    win_pol  = pol_sel[win_idx];
    irq_d    = irq_q;
    pulse_d  = pulse_q;
    if (win_vld) begin
      pulse_d = win_edge;
      irq_d   = win_edge | win_pol;
    end else if (pulse_q) begin
      pulse_d = 1'b0;
      irq_d   = 1'b0;
    end
    upd_en = win_vld | pulse_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else if (upd_en) begin
      irq_q   <= irq_d;
      pulse_q <= pulse_d;
    end
  end

  assign irq = irq_q;

  // R7: pulse rises after an edge-mode win and drops one cycle later
  a_r7_pulse_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (win_vld && edge_sel[win_idx]) |=> irq_q);
  a_r7_pulse_end: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_q && !win_vld) |=> !irq_q);
  // R8: level win with polarity 1 raises
  a_r8_level_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (win_vld && !edge_sel[win_idx] && pol_sel[win_idx]) |=> (irq_q && !pulse_q));
  // R9: level win with polarity 0 lowers
  a_r9_level_lower: assert property (@(posedge clk) disable iff (!rst_n)
    (win_vld && !edge_sel[win_idx] && !pol_sel[win_idx]) |=> !irq_q);
  // R8: a level value holds while nothing happens
  a_r8_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_vld && !pulse_q) |=> $stable(irq_q));

endmodule

// File: rtl/pci_intx_router.sv
module pci_intx_router #(
  parameter int NUM_SLOTS = 16,
  parameter int NUM_LINES = 32
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic [NUM_SLOTS*pirq_pkg::PINS_PER_SLOT-1:0] intx_lvl,
  input  logic [NUM_LINES-1:0]                     edge_sel,
  input  logic [NUM_LINES-1:0]                     pol_sel,
  output logic                                     cpu_irq
);

  localparam int NUM_IN = NUM_SLOTS * pirq_pkg::PINS_PER_SLOT;
  localparam int LW     = $clog2(NUM_LINES);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [NUM_IN-1:0]    pin_evt;
  logic [NUM_LINES-1:0] line_evt;
  logic                 win_vld;
  logic [LW-1:0]        win_idx;

  pirq_change_det #(.NUM_IN(NUM_IN)) u_det (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .lvl   (intx_lvl),
    .evt   (pin_evt)
  );

  pirq_slot_map #(.NUM_SLOTS(NUM_SLOTS), .NUM_LINES(NUM_LINES)) u_map (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .pin_evt  (pin_evt),
    .line_evt (line_evt)
  );

  pirq_prio_pick #(.NUM_LINES(NUM_LINES)) u_pick (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .line_evt (line_evt),
    .win_vld  (win_vld),
    .win_idx  (win_idx)
  );

  pirq_out_ctl #(.NUM_LINES(NUM_LINES)) u_out (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .win_vld  (win_vld),
    .win_idx  (win_idx),
    .edge_sel (edge_sel),
    .pol_sel  (pol_sel),
    .irq      (cpu_irq)
  );

  // R1: output is low while the internal reset is held
  a_r1_reset_low: assert property (@(posedge clk)
    (!rst_sync_q && !$isunknown(rst_sync_q)) |-> !cpu_irq);

endmodule

// File: tb/pci_intx_router_tb_top.sv
module pci_intx_router_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int SLOTS = 16;
  localparam int LINES = 32;
  localparam int NIN   = SLOTS * 4;

  logic             clk;
  logic             rst_n;
  logic [NIN-1:0]   lvl;
  logic [LINES-1:0] edge_m;
  logic [LINES-1:0] pol_m;
  logic             irq;

  int errs;
  int checks;
  bit done;

  pci_intx_router #(.NUM_SLOTS(SLOTS), .NUM_LINES(LINES)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .intx_lvl (lvl),
    .edge_sel (edge_m),
    .pol_sel  (pol_m),
    .cpu_irq  (irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  task automatic check(input logic got, input logic exp, input string what);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s got=%0b exp=%0b", what, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  // line expected from the requirement text, -1 when unrouted
  function automatic int exp_line(input int s, input int p);
    if (s == 5) return p;            // R3
    if (s == 6) return 4;            // R4
    if (s == 7) return 5;            // R4
    if (s >= 8 && s <= 12) return s - 2 + p;  // R5: (s-8+p)+6
    return -1;                       // R6
  endfunction

  function automatic string grp_tag(input int s);
    if (s == 5) return "R3";
    if (s == 6 || s == 7) return "R4";
    if (s >= 8 && s <= 12) return "R5";
    return "R6";
  endfunction

  // helper pin: slot 5 pin 0 -> line 0
  task automatic force_low();
    edge_m = '0; pol_m = '0;
    lvl[20] = ~lvl[20];
    tick(); tick();
  endtask

  task automatic force_high();
    edge_m = '0; pol_m = '1;
    lvl[20] = ~lvl[20];
    tick(); tick();
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    errs++; checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    errs = 0; checks = 0; done = 1'b0;
    rst_n = 1'b0; lvl = '0; edge_m = '0; pol_m = '1;
    tick(); tick();
    lvl = '1;   // changes during reset must not leak out
    tick();
    check(irq, 1'b0, "R1 during reset");
    lvl = '0;
    tick();
    rst_n = 1'b1;
    repeat (4) tick();
    check(irq, 1'b0, "R1 after reset release");

    // R2: stable inputs, any mask, no change
    pol_m = '1;
    repeat (3) tick();
    check(irq, 1'b0, "R2 stable inputs keep output");

    // R2: falling change counts as event (slot 7 pin 2 -> line 5)
    force_low();
    pol_m = 32'h1 << 5;
    lvl[30] = 1'b1;
    tick();
    check(irq, 1'b1, "R2 rising change raises");
    force_low();
    pol_m = 32'h1 << 5;
    lvl[30] = 1'b0;
    tick();
    check(irq, 1'b1, "R2 falling change raises");

    // sweep every pin of every slot through three handlings
    for (int s = 0; s < SLOTS; s++) begin
      for (int p = 0; p < 4; p++) begin
        int ln;
        logic hit;
        string tg;
        ln  = exp_line(s, p);
        hit = (ln >= 0);
        tg  = grp_tag(s);

        force_low();
        edge_m = '0;
        pol_m  = hit ? (32'h1 << ln) : '0;
        lvl[s*4+p] = ~lvl[s*4+p];
        #1;
        check(irq, 1'b0, $sformatf("R11 before edge slot=%0d pin=%0d", s, p));
        tick();
        check(irq, hit, $sformatf("%s/R8 raise slot=%0d pin=%0d", tg, s, p));
        tick();
        check(irq, hit, $sformatf("%s/R8 hold slot=%0d pin=%0d", tg, s, p));

        force_low();
        edge_m = hit ? (32'h1 << ln) : '0;
        pol_m  = '0;
        lvl[s*4+p] = ~lvl[s*4+p];
        tick();
        check(irq, hit, $sformatf("%s/R7 pulse high slot=%0d pin=%0d", tg, s, p));
        tick();
        check(irq, 1'b0, $sformatf("%s/R7 pulse end slot=%0d pin=%0d", tg, s, p));

        force_high();
        edge_m = '0;
        pol_m  = hit ? ~(32'h1 << ln) : '1;
        lvl[s*4+p] = ~lvl[s*4+p];
        tick();
        check(irq, ~hit, $sformatf("%s/R9 lower slot=%0d pin=%0d", tg, s, p));
        tick();
        check(irq, ~hit, $sformatf("%s/R9 hold slot=%0d pin=%0d", tg, s, p));
      end
    end

    // R10: line 1 (slot5 pin1) against line 4 (slot6 pin0)
    force_low();
    pol_m = 32'h1 << 1;
    lvl[21] = ~lvl[21]; lvl[24] = ~lvl[24];
    tick();
    check(irq, 1'b1, "R10 line1 raise beats line4 lower");
    force_high();
    pol_m = ~(32'h1 << 1);
    lvl[21] = ~lvl[21]; lvl[24] = ~lvl[24];
    tick();
    check(irq, 1'b0, "R10 line1 lower beats line4 raise");
    // R10: line 4 edge against line 6 (slot8 pin0) raise
    force_low();
    edge_m = 32'h1 << 4;
    pol_m  = 32'h1 << 6;
    lvl[24] = ~lvl[24]; lvl[32] = ~lvl[32];
    tick();
    check(irq, 1'b1, "R10 line4 pulse high");
    tick();
    check(irq, 1'b0, "R10 line4 pulse end, line6 ignored");
    // R10: unrouted pin together with routed one
    force_high();
    pol_m = ~(32'h1 << 13);
    lvl[0] = ~lvl[0]; lvl[51] = ~lvl[51];   // slot0 pin0, slot12 pin3 -> line 13
    tick();
    check(irq, 1'b0, "R10 line13 decides with unrouted pin");

    summary();
  end

endmodule